// File: doc/BRIEF.md
# Asymmetric Dual-Issue Pairing Unit

This unit sits between an instruction fetch buffer and two execution pipes. One is a short integer-side pipe. The other is a longer floating-point computation pipe. Each cycle it looks at the two oldest instructions in the buffer and sorts each into a class. It then decides whether both can go to their pipes together, only the older one can go, or neither can. It reports the result one clock later as issue strobes, the instruction word for each pipe, the class of each slot and a shift count for the fetch buffer.

Pairing is asymmetric. A pair issues only when one instruction is integer-side and the other is a floating-point computation. Floating-point loads and stores, moves between register files and floating-point branches all count as integer-side.

Issue stays in program order. A younger instruction never goes alone, and it is held back by any of the following:
- a branch in the older slot,
- a floating-point register conflict with the older instruction,
- its pipe being busy.

A small scoreboard covers the full depth of the floating-point pipe. It marks each destination register of an issued floating-point computation as in flight, and any instruction that touches that register waits until the result has cleared the pipe.

Top module: `dual_issue_pairer`

## Requirements
- R1: Classification uses bits 31:26 of the instruction word.
  - Opcode 6'h11 with bits 25:21 equal to 16, 17, 20 or 21 is a floating-point computation.
  - Opcode 6'h13 with bits 5:4 equal to 2'b10 is a floating-point computation.
  - Every other word is integer-side. This includes FP loads 6'h31 and 6'h35 and FP stores 6'h39 and 6'h3D.
  - The slot class outputs report 1 for the floating-point pipe and 0 for the integer pipe.
- R2: When slot 0 and slot 1 are both valid, of different classes and free of every hazard below, both issue. consume is 2 and both issue strobes are set.
- R3: Two valid instructions of the same class never pair. Only slot 0 issues and consume is 1.
- R4: If slot 0 cannot issue, slot 1 does not issue either and consume is 0.
- R5: A branch in slot 0 never pairs with slot 1. Branches are:
  - opcodes 1 to 7,
  - opcode 0 with bits 5:0 equal to 8 or 9,
  - opcode 6'h11 with bits 25:21 equal to 8.
  A branch in slot 1 may pair with a floating-point computation in slot 0.
- R6: Slot 1 does not issue if it reads or writes a floating-point register that slot 0 writes. The register fields are:
  - A computation writes bits 10:6 and reads bits 15:11 and 20:16. A multiply-add (opcode 6'h13) also reads bits 25:21.
  - An FP load writes bits 20:16 and an FP store reads bits 20:16.
  - A move to the FP file (opcode 6'h11, bits 25:21 = 4) writes bits 15:11. A move from it (bits 25:21 = 0) reads bits 15:11.
- R7: A high int_busy blocks every integer-side instruction. A high fp_busy blocks every floating-point computation.
- R8: A floating-point computation marks its destination register busy for FP_STAGES cycles after it issues. A reader of that register, or an integer-side writer of it, is refused on each of those FP_STAGES cycles and issues on the next.
- R9: Every output is registered. A decision appears one clock after the inputs are presented. A synchronous active-high reset clears all outputs to zero.
- R10: When slot 0 is not valid, nothing issues, even with slot 1 valid. When only slot 0 is valid, at most one instruction issues.
- R11: int_instr carries the word of the issued integer-side instruction and fp_instr carries the word of the issued floating-point computation, from whichever slot each came.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot0_valid | input | 1 | Older buffer entry present |
| slot0_instr | input | 32 | Older instruction word |
| slot1_valid | input | 1 | Younger buffer entry present |
| slot1_instr | input | 32 | Younger instruction word |
| int_busy | input | 1 | Integer pipe cannot accept |
| fp_busy | input | 1 | Floating-point pipe cannot accept |
| int_valid | output | 1 | Issue strobe to the integer pipe |
| int_instr | output | 32 | Word sent to the integer pipe |
| fp_valid | output | 1 | Issue strobe to the floating-point pipe |
| fp_instr | output | 32 | Word sent to the floating-point pipe |
| slot0_fp | output | 1 | Class of slot 0 (1 = floating-point pipe) |
| slot1_fp | output | 1 | Class of slot 1 (1 = floating-point pipe) |
| consume | output | 2 | Entries the fetch buffer shifts out (0, 1 or 2) |

## Verification
Several of the block's refusal causes can land on the same cycle. In particular, the in-flight scoreboard hold on a register can coincide with a pair that is otherwise valid.

The scoreboard case is provoked by issuing a floating-point add and then presenting a dependent store on each following cycle. The store must be refused for exactly FP_STAGES decisions and accepted on the next.

The pair split cases are provoked by holding a mixed-class pair in place while one cause at a time is changed: a same-pair register conflict, a branch in the older slot, or a busy pipe. Each case is judged by the consume count and the two issue strobes one clock after presentation. Each case is also checked to see whether the younger instruction's word appears on its pipe.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int WORD_W = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_REGIMM  = 6'h01;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] OP_BLEZ    = 6'h06;
  localparam logic [5:0] OP_BGTZ    = 6'h07;
  localparam logic [5:0] OP_FPOP    = 6'h11;
  localparam logic [5:0] OP_FPFUSED = 6'h13;
  localparam logic [5:0] OP_FLDW    = 6'h31;
  localparam logic [5:0] OP_FLDD    = 6'h35;
  localparam logic [5:0] OP_FSTW    = 6'h39;
  localparam logic [5:0] OP_FSTD    = 6'h3D;

  localparam logic [4:0] FMT_MOVE_FROM = 5'd0;
  localparam logic [4:0] FMT_MOVE_TO   = 5'd4;
  localparam logic [4:0] FMT_FBRANCH   = 5'd8;
  localparam logic [4:0] FMT_SINGLE    = 5'd16;
  localparam logic [4:0] FMT_DOUBLE    = 5'd17;
  localparam logic [4:0] FMT_WORD      = 5'd20;
  localparam logic [4:0] FMT_LONG      = 5'd21;

  localparam logic [5:0] FN_JR   = 6'h08;
  localparam logic [5:0] FN_JALR = 6'h09;

  typedef enum logic {
    PIPE_INT = 1'b0,
    PIPE_FP  = 1'b1
  } pipe_e;

endpackage

// File: rtl/dip_classify.sv
module dip_classify
  import dip_pkg::*;
#(
  parameter int NFPR = 32
) (
  input  logic [WORD_W-1:0] instr,
  output logic              is_fp,
  output logic              is_branch,
  output logic [NFPR-1:0]   fp_rd,
  output logic [NFPR-1:0]   fp_wr
);

  logic [5:0] op;
  logic [4:0] f_hi;
  logic [4:0] f_t;
  logic [4:0] f_s;
  logic [4:0] f_d;
  logic [5:0] fn;

  assign op   = instr[31:26];
  assign f_hi = instr[25:21];
  assign f_t  = instr[20:16];
  assign f_s  = instr[15:11];
  assign f_d  = instr[10:6];
  assign fn   = instr[5:0];

  function automatic logic [NFPR-1:0] reg_bit(input logic [4:0] idx);
    return NFPR'(1) << idx;
  endfunction

  always_comb begin
    is_fp     = 1'b0;
    is_branch = 1'b0;
    fp_rd     = '0;
    fp_wr     = '0;
    case (op)
      OP_FPOP: begin
        if (f_hi == FMT_SINGLE || f_hi == FMT_DOUBLE ||
            f_hi == FMT_WORD   || f_hi == FMT_LONG) begin
          is_fp = 1'b1;
          fp_rd = reg_bit(f_s) | reg_bit(f_t);
          fp_wr = reg_bit(f_d);
        end else if (f_hi == FMT_MOVE_FROM) begin
          fp_rd = reg_bit(f_s);
        end else if (f_hi == FMT_MOVE_TO) begin
          fp_wr = reg_bit(f_s);
        end else if (f_hi == FMT_FBRANCH) begin
          is_branch = 1'b1;
        end
      end
      OP_FPFUSED: begin
        if (fn[5:4] == 2'b10) begin
          is_fp = 1'b1;
          fp_rd = reg_bit(f_hi) | reg_bit(f_s) | reg_bit(f_t);
          fp_wr = reg_bit(f_d);
        end
      end
      OP_FLDW, OP_FLDD: fp_wr = reg_bit(f_t);
      OP_FSTW, OP_FSTD: fp_rd = reg_bit(f_t);
      OP_SPECIAL:       is_branch = (fn == FN_JR) || (fn == FN_JALR);
      OP_REGIMM, OP_J, OP_JAL, OP_BEQ, OP_BNE, OP_BLEZ, OP_BGTZ:
                        is_branch = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/dip_fp_scoreboard.sv
module dip_fp_scoreboard #(
  parameter int NFPR        = 32,
  parameter int TRACK_DEPTH = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [NFPR-1:0] load_mask,
  output logic [NFPR-1:0] pending
);

  localparam int CNT_W = $clog2(TRACK_DEPTH + 1);

  for (genvar r = 0; r < NFPR; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic             hit;

    assign hit        = load_en && load_mask[r];
    assign pending[r] = (cnt != '0);

    always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (hit)         cnt <= CNT_W'(TRACK_DEPTH);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // R8: an in-flight count only ever drains by one per cycle
    a_r8_drain: assert property (@(posedge clk) disable iff (rst)
      (cnt != '0 && !hit) |=> (cnt == $past(cnt) - 1'b1));
  end

  // R8: a loaded register reads as pending on the next cycle
  a_r8_load_marks: assert property (@(posedge clk) disable iff (rst)
    (load_en && load_mask != '0) |=> ((pending & $past(load_mask)) != '0));

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dip_pkg::*;
#(
  parameter int NFPR       = 32,
  parameter int INT_STAGES = 5,
  parameter int FP_STAGES  = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        slot0_valid,
  input  logic [31:0] slot0_instr,
  input  logic        slot1_valid,
  input  logic [31:0] slot1_instr,
  input  logic        int_busy,
  input  logic        fp_busy,
  output logic        int_valid,
  output logic [31:0] int_instr,
  output logic        fp_valid,
  output logic [31:0] fp_instr,
  output logic        slot0_fp,
  output logic        slot1_fp,
  output logic [1:0]  consume
);

  localparam int NSLOT       = 2;
  localparam int TRACK_DEPTH = (FP_STAGES > INT_STAGES) ? FP_STAGES : INT_STAGES;

  logic [WORD_W-1:0] word   [NSLOT];
  logic              vld    [NSLOT];
  logic              is_fp  [NSLOT];
  logic              is_br  [NSLOT];
  logic [NFPR-1:0]   rd_m   [NSLOT];
  logic [NFPR-1:0]   wr_m   [NSLOT];
  logic              held   [NSLOT];
  pipe_e             cls    [NSLOT];
  logic [NFPR-1:0]   pend;

  assign word[0] = slot0_instr;
  assign word[1] = slot1_instr;
  assign vld[0]  = slot0_valid;
  assign vld[1]  = slot1_valid;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    dip_classify #(.NFPR(NFPR)) u_cls (
      .instr     (word[s]),
      .is_fp     (is_fp[s]),
      .is_branch (is_br[s]),
      .fp_rd     (rd_m[s]),
      .fp_wr     (wr_m[s])
    );
    assign cls[s]  = is_fp[s] ? PIPE_FP : PIPE_INT;
    assign held[s] = (is_fp[s] ? fp_busy : int_busy)
                   || ((rd_m[s] & pend) != '0)
                   || (!is_fp[s] && ((wr_m[s] & pend) != '0));
  end

  logic go0, go1, pair_clash;
  logic int_go, fp_go;
  logic [WORD_W-1:0] int_word, fp_word;
  logic [NFPR-1:0]   fp_dest;

  assign pair_clash = (wr_m[0] & (rd_m[1] | wr_m[1])) != '0;
  assign go0 = vld[0] && !held[0];
  assign go1 = go0 && vld[1] && (cls[1] != cls[0]) && !is_br[0]
            && !held[1] && !pair_clash;

  always_comb begin
    int_go   = 1'b0;
    fp_go    = 1'b0;
    int_word = '0;
    fp_word  = '0;
    fp_dest  = '0;
    if (go0) begin
      if (cls[0] == PIPE_FP) begin
        fp_go = 1'b1; fp_word = word[0]; fp_dest = wr_m[0];
      end else begin
        int_go = 1'b1; int_word = word[0];
      end
    end
    if (go1) begin
      if (cls[1] == PIPE_FP) begin
        fp_go = 1'b1; fp_word = word[1]; fp_dest = wr_m[1];
      end else begin
        int_go = 1'b1; int_word = word[1];
      end
    end
  end

  dip_fp_scoreboard #(.NFPR(NFPR), .TRACK_DEPTH(TRACK_DEPTH)) u_sb (
    .clk       (clk),
    .rst       (rst),
    .load_en   (fp_go),
    .load_mask (fp_dest),
    .pending   (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      int_valid <= 1'b0;
      int_instr <= '0;
      fp_valid  <= 1'b0;
      fp_instr  <= '0;
      slot0_fp  <= 1'b0;
      slot1_fp  <= 1'b0;
      consume   <= 2'd0;
    end else begin
      int_valid <= int_go;
      int_instr <= int_word;
      fp_valid  <= fp_go;
      fp_instr  <= fp_word;
      slot0_fp  <= (cls[0] == PIPE_FP);
      slot1_fp  <= (cls[1] == PIPE_FP);
      consume   <= {1'b0, go0} + {1'b0, go1};
    end
  end

  // R2: both pipes fed only by one instruction of each class
  a_r2_mixed_pair: assert property (@(posedge clk) disable iff (rst)
    (int_valid && fp_valid) |-> (slot0_fp != slot1_fp));

  // R9: the shift count matches the number of strobes raised
  a_r9_count_matches: assert property (@(posedge clk) disable iff (rst)
    consume == 2'($countones({int_valid, fp_valid})));

  // R7: a busy pipe receives nothing on the following cycle
  a_r7_int_busy: assert property (@(posedge clk) disable iff (rst)
    int_busy |=> !int_valid);
  a_r7_fp_busy: assert property (@(posedge clk) disable iff (rst)
    fp_busy |=> !fp_valid);

  // R10: no older entry, no issue
  a_r10_empty_head: assert property (@(posedge clk) disable iff (rst)
    !slot0_valid |=> (consume == 2'd0));

  // R5: an older branch stands alone
  a_r5_branch_alone: assert property (@(posedge clk) disable iff (rst)
    (slot0_valid && is_br[0]) |=> (consume != 2'd2));

endmodule

// File: tb/dual_issue_pairer_bench.sv
`timescale 1ns/1ps
module dual_issue_pairer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slot0_valid = 1'b0;
  logic [31:0] slot0_instr = '0;
  logic        slot1_valid = 1'b0;
  logic [31:0] slot1_instr = '0;
  logic        int_busy = 1'b0;
  logic        fp_busy = 1'b0;
  logic        int_valid, fp_valid, slot0_fp, slot1_fp;
  logic [31:0] int_instr, fp_instr;
  logic [1:0]  consume;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_issue_pairer u_dual_issue_pairer (
    .clk(clk), .rst(rst),
    .slot0_valid(slot0_valid), .slot0_instr(slot0_instr),
    .slot1_valid(slot1_valid), .slot1_instr(slot1_instr),
    .int_busy(int_busy), .fp_busy(fp_busy),
    .int_valid(int_valid), .int_instr(int_instr),
    .fp_valid(fp_valid), .fp_instr(fp_instr),
    .slot0_fp(slot0_fp), .slot1_fp(slot1_fp),
    .consume(consume)
  );

  function automatic logic [31:0] i_add(input int d, input int a, input int b);
    return {6'h00, 5'(a), 5'(b), 5'(d), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] i_fadd(input int d, input int s, input int t);
    return {6'h11, 5'd16, 5'(t), 5'(s), 5'(d), 6'h00};
  endfunction
  function automatic logic [31:0] i_cvt(input int d, input int s);
    return {6'h11, 5'd16, 5'd30, 5'(s), 5'(d), 6'h21};
  endfunction
  function automatic logic [31:0] i_madd(input int d, input int r, input int s, input int t);
    return {6'h13, 5'(r), 5'(t), 5'(s), 5'(d), 6'b100000};
  endfunction
  function automatic logic [31:0] i_fload(input int t);
    return {6'h31, 5'd2, 5'(t), 16'h0010};
  endfunction
  function automatic logic [31:0] i_fstore(input int t);
    return {6'h39, 5'd2, 5'(t), 16'h0020};
  endfunction
  function automatic logic [31:0] i_beq();
    return {6'h04, 5'd1, 5'd2, 16'h0004};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic present(input logic v0, input logic [31:0] w0,
                         input logic v1, input logic [31:0] w1,
                         input logic ib, input logic fb);
    @(negedge clk);
    slot0_valid = v0; slot0_instr = w0;
    slot1_valid = v1; slot1_instr = w1;
    int_busy = ib; fp_busy = fb;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    slot0_valid = 1'b0; slot1_valid = 1'b0;
    int_busy = 1'b0; fp_busy = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_issue(input string req, input logic iv, input logic fv,
                              input logic [1:0] c);
    chk({req, " int_valid"}, 32'(int_valid), 32'(iv));
    chk({req, " fp_valid"},  32'(fp_valid),  32'(fv));
    chk({req, " consume"},   32'(consume),   32'(c));
  endtask

  task automatic t_reset();
    @(negedge clk);
    expect_issue("R9 reset", 1'b0, 1'b0, 2'd0);
    chk("R9 reset slot0_fp", 32'(slot0_fp), 32'd0);
  endtask

  task automatic t_pair();
    present(1'b1, i_add(3, 4, 5), 1'b1, i_fadd(10, 11, 12), 1'b0, 1'b0);
    expect_issue("R2 int+fp", 1'b1, 1'b1, 2'd2);
    chk("R11 int word", int_instr, i_add(3, 4, 5));
    chk("R11 fp word", fp_instr, i_fadd(10, 11, 12));
    chk("R1 slot0 class", 32'(slot0_fp), 32'd0);
    chk("R1 slot1 class", 32'(slot1_fp), 32'd1);
    idle(10);
    present(1'b1, i_madd(13, 14, 15, 16), 1'b1, i_add(6, 7, 8), 1'b0, 1'b0);
    expect_issue("R2 fp+int", 1'b1, 1'b1, 2'd2);
    chk("R11 int from slot1", int_instr, i_add(6, 7, 8));
    chk("R11 fp from slot0", fp_instr, i_madd(13, 14, 15, 16));
    idle(10);
  endtask

  task automatic t_fp_memory_class();
    present(1'b1, i_fload(20), 1'b1, i_cvt(21, 22), 1'b0, 1'b0);
    expect_issue("R1 fp load is int side", 1'b1, 1'b1, 2'd2);
    chk("R1 fp load class", 32'(slot0_fp), 32'd0);
    idle(10);
    present(1'b1, i_cvt(23, 24), 1'b1, i_fstore(25), 1'b0, 1'b0);
    expect_issue("R1 fp store is int side", 1'b1, 1'b1, 2'd2);
    chk("R1 store word on int pipe", int_instr, i_fstore(25));
    idle(10);
  endtask

  task automatic t_same_class();
    present(1'b1, i_add(3, 4, 5), 1'b1, i_fload(9), 1'b0, 1'b0);
    expect_issue("R3 int+int", 1'b1, 1'b0, 2'd1);
    chk("R3 older word", int_instr, i_add(3, 4, 5));
    idle(10);
    present(1'b1, i_fadd(10, 11, 12), 1'b1, i_madd(13, 14, 15, 16), 1'b0, 1'b0);
    expect_issue("R3 fp+fp", 1'b0, 1'b1, 2'd1);
    chk("R3 older fp word", fp_instr, i_fadd(10, 11, 12));
    idle(10);
  endtask

  task automatic t_branch();
    present(1'b1, i_beq(), 1'b1, i_fadd(10, 11, 12), 1'b0, 1'b0);
    expect_issue("R5 branch first", 1'b1, 1'b0, 2'd1);
    idle(10);
    present(1'b1, i_fadd(10, 11, 12), 1'b1, i_beq(), 1'b0, 1'b0);
    expect_issue("R5 branch second", 1'b1, 1'b1, 2'd2);
    idle(10);
  endtask

  task automatic t_pair_dependence();
    present(1'b1, i_fadd(5, 11, 12), 1'b1, i_fstore(5), 1'b0, 1'b0);
    expect_issue("R6 store reads fp result", 1'b0, 1'b1, 2'd1);
    idle(10);
    present(1'b1, i_fload(7), 1'b1, i_fadd(8, 7, 12), 1'b0, 1'b0);
    expect_issue("R6 fp reads loaded reg", 1'b1, 1'b0, 2'd1);
    idle(10);
  endtask

  task automatic t_busy();
    present(1'b1, i_add(3, 4, 5), 1'b1, i_fadd(10, 11, 12), 1'b1, 1'b0);
    expect_issue("R4 older int blocked", 1'b0, 1'b0, 2'd0);
    idle(10);
    present(1'b1, i_add(3, 4, 5), 1'b1, i_fadd(10, 11, 12), 1'b0, 1'b1);
    expect_issue("R7 fp pipe busy", 1'b1, 1'b0, 2'd1);
    idle(10);
    present(1'b1, i_fadd(10, 11, 12), 1'b1, i_add(3, 4, 5), 1'b0, 1'b1);
    expect_issue("R4 older fp blocked", 1'b0, 1'b0, 2'd0);
    idle(10);
  endtask

  task automatic t_valid();
    present(1'b0, i_add(3, 4, 5), 1'b1, i_fadd(10, 11, 12), 1'b0, 1'b0);
    expect_issue("R10 empty head", 1'b0, 1'b0, 2'd0);
    idle(10);
    present(1'b1, i_add(3, 4, 5), 1'b0, i_fadd(10, 11, 12), 1'b0, 1'b0);
    expect_issue("R10 single entry", 1'b1, 1'b0, 2'd1);
    idle(10);
  endtask

  task automatic t_latency();
    @(negedge clk);
    slot0_valid = 1'b1; slot0_instr = i_add(3, 4, 5);
    slot1_valid = 1'b0;
    #1;
    chk("R9 not yet visible", 32'(int_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 visible after one edge", 32'(int_valid), 32'd1);
    idle(10);
  endtask

  task automatic t_scoreboard();
    present(1'b1, i_fadd(3, 11, 12), 1'b0, '0, 1'b0, 1'b0);
    chk("R8 producer issued", 32'(fp_valid), 32'd1);
    slot0_instr = i_fstore(3);
    for (int k = 0; k < 7; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R8 reader held", 32'(int_valid), 32'd0);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R8 reader released", 32'(int_valid), 32'd1);
    idle(10);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    t_pair();
    t_fp_memory_class();
    t_same_class();
    t_branch();
    t_pair_dependence();
    t_busy();
    t_valid();
    t_latency();
    t_scoreboard();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule